// File: doc/BRIEF.md
# TDM Time Slot Assigner

The block sits between one multiplexed serial line (a receive bit and a transmit bit) and up to six internal serial channels. A time-division frame on the line is cut into runs by a routing list held in a 64-entry memory of 16-bit words. The host loads that list. Each word picks a channel (or none), a run length, and a set of active-high strobe outputs that stay asserted for that run. The run length is 1 to 16 units, and the unit is either one bit or one byte.

The block's clock is the serial bit clock, so every clock is one line bit. A frame sync pulse seen while the block is enabled restarts a sequencer at entry 0. The sequencer then walks the list one bit per clock. It enables the clock of the selected channel only, passes that channel's transmit bit to the line, and hands the received line bit to that channel alone. Entry writes go through a small write port while the block is disabled. A control write on the same port sets or clears the enable bit.

Top module: `tdm_slot_assigner`

## Requirements
- R1: After synchronous reset the block is disabled, every channel clock enable and strobe is low, and the line transmit bit is high.
- R2: A frame sync that is high at a clock edge while the block is enabled makes entry 0 drive the outputs from the following cycle.
- R3: An entry with bit 8 clear (bit mode) holds its routing for exactly count+1 cycles, where count is bits [7:4].
- R4: An entry with bit 8 set (byte mode) holds its routing for exactly 8×(count+1) cycles.
- R5: The channel field is bits [15:13]. Value k in 1..6 raises only clock enable k-1. Values 0 and 7 raise no enable, and during such a run the line transmit bit is high.
- R6: During a run for channel k, the line transmit bit equals that channel's transmit input. The received line bit appears on that channel's receive output only, and all other receive outputs are low.
- R7: Strobe output j is high for the whole run of an entry whose bit 9+j is set, and low otherwise.
- R8: The sequencer stops after an entry with bit 0 set, or after entry 63. From the next cycle it holds every enable and strobe low and the transmit bit high until the next frame sync.
- R9: A frame sync during a run abandons it and restarts at entry 0 in the next cycle.
- R10: While disabled, frame sync is ignored and the outputs stay idle.
- R11: An entry write (control select low) made while the block is enabled leaves the stored list unchanged.
- R12: A control write with data bit 0 clear disables the block and leaves all outputs idle from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe of the configuration port |
| cfg_ctl | input | 1 | 1 selects the control word (bit 0 = enable); 0 selects a list entry |
| cfg_addr | input | 6 | Entry index for entry writes |
| cfg_wdata | input | 16 | Write data |
| fsync | input | 1 | Frame sync pulse |
| line_rxd | input | 1 | Receive bit from the multiplexed line |
| line_txd | output | 1 | Transmit bit to the multiplexed line |
| ch_txd | input | 6 | Transmit bits of the internal channels |
| ch_clken | output | 6 | Per-channel clock enables |
| ch_rxd | output | 6 | Per-channel receive bits |
| strobe | output | 4 | Active-high strobe outputs |

## Verification
The assertions assume that fsync and the configuration port are driven synchronously and are free of X after reset. They also assume the list is written before any sync arrives while the block is enabled, because a read of an unwritten entry gives undefined routing. The stimulus keeps to this by clearing the enable before each list load, writing every entry the frame can reach, and only then setting the enable. It changes inputs on the falling edge only.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

    localparam int ENTRY_W  = 16;
    localparam int CHSEL_W  = 3;
    localparam int STB_N    = 4;
    localparam int CNT_W    = 4;
    localparam int RUN_W    = 7;   // longest run is 128 bits, held as length-1

    typedef struct packed {
        logic [CHSEL_W-1:0] chan;
        logic [STB_N-1:0]   stb;
        logic               byte_mode;
        logic [CNT_W-1:0]   cnt;
        logic [2:0]         rsvd;
        logic               last;
    } route_word_t;

    // Number of bit cycles in a run, minus one.
    function automatic logic [RUN_W-1:0] run_minus1(route_word_t w);
        logic [RUN_W-1:0] units;
        units = RUN_W'(w.cnt) + RUN_W'(1);
        if (w.byte_mode)
            return (units << 3) - RUN_W'(1);
        return units - RUN_W'(1);
    endfunction

endpackage

// File: rtl/tsa_route_mem.sv
module tsa_route_mem
    import tsa_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr,
    input  logic               cfg_ctl,
    input  logic [AW-1:0]      cfg_addr,
    input  logic [ENTRY_W-1:0] cfg_wdata,
    input  logic [AW-1:0]      rd_addr,
    output route_word_t        rd_word,
    output logic               run_en
);

    logic [ENTRY_W-1:0] mem [DEPTH];
    logic               en_q;
    logic               clear_now;

    assign clear_now = cfg_wr && cfg_ctl && !cfg_wdata[0];
    assign run_en    = en_q && !clear_now;
    assign rd_word   = route_word_t'(mem[rd_addr]);

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else if (cfg_wr && cfg_ctl)
            en_q <= cfg_wdata[0];
    end

    // Contents are left undefined by reset; writes only while disabled.
    always_ff @(posedge clk) begin
        if (cfg_wr && !cfg_ctl && !en_q)
            mem[cfg_addr] <= cfg_wdata;
    end

endmodule

// File: rtl/tsa_sequencer.sv
module tsa_sequencer
    import tsa_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run_en,
    input  logic           fsync,
    input  route_word_t    rd_word,
    output logic [AW-1:0]  rd_addr,
    output logic           active,
    output route_word_t    cur,
    output logic [RUN_W-1:0] rem
);

    logic [AW-1:0] idx;
    logic          at_end;

    assign at_end  = cur.last || (idx == AW'(DEPTH - 1));
    assign rd_addr = fsync ? '0 : idx + AW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
            cur    <= '0;
            rem    <= '0;
        end else if (!run_en) begin
            active <= 1'b0;
        end else if (fsync) begin
            active <= 1'b1;
            idx    <= '0;
            cur    <= rd_word;
            rem    <= run_minus1(rd_word);
        end else if (active) begin
            if (rem != '0) begin
                rem <= rem - RUN_W'(1);
            end else if (at_end) begin
                active <= 1'b0;
            end else begin
                idx <= idx + AW'(1);
                cur <= rd_word;
                rem <= run_minus1(rd_word);
            end
        end
    end

endmodule

// File: rtl/tsa_lane_mux.sv
module tsa_lane_mux
    import tsa_pkg::*;
#(
    parameter int NCH = 6
) (
    input  logic              active,
    input  route_word_t       cur,
    input  logic [NCH-1:0]    ch_txd,
    input  logic              line_rxd,
    output logic [NCH-1:0]    ch_clken,
    output logic [NCH-1:0]    ch_rxd,
    output logic              line_txd,
    output logic [STB_N-1:0]  strobe
);

    logic [NCH-1:0] sel;

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        assign sel[g]      = active && (cur.chan == CHSEL_W'(g + 1));
        assign ch_clken[g] = sel[g];
        assign ch_rxd[g]   = sel[g] && line_rxd;
    end

    assign line_txd = (sel == '0) ? 1'b1 : |(sel & ch_txd);
    assign strobe   = active ? cur.stb : '0;

endmodule

// File: rtl/tdm_slot_assigner.sv
module tdm_slot_assigner
    import tsa_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int NCH   = 6,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr,
    input  logic               cfg_ctl,
    input  logic [AW-1:0]      cfg_addr,
    input  logic [ENTRY_W-1:0] cfg_wdata,
    input  logic               fsync,
    input  logic               line_rxd,
    output logic               line_txd,
    input  logic [NCH-1:0]     ch_txd,
    output logic [NCH-1:0]     ch_clken,
    output logic [NCH-1:0]     ch_rxd,
    output logic [STB_N-1:0]   strobe
);

    route_word_t      rd_word;
    route_word_t      cur;
    logic [AW-1:0]    rd_addr;
    logic             run_en;
    logic             active;
    logic [RUN_W-1:0] rem;

    tsa_route_mem #(.DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_ctl(cfg_ctl),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rd_addr(rd_addr), .rd_word(rd_word), .run_en(run_en)
    );

    tsa_sequencer #(.DEPTH(DEPTH)) u_seq (
        .clk(clk), .rst(rst), .run_en(run_en), .fsync(fsync),
        .rd_word(rd_word), .rd_addr(rd_addr), .active(active),
        .cur(cur), .rem(rem)
    );

    tsa_lane_mux #(.NCH(NCH)) u_mux (
        .active(active), .cur(cur), .ch_txd(ch_txd), .line_rxd(line_rxd),
        .ch_clken(ch_clken), .ch_rxd(ch_rxd), .line_txd(line_txd),
        .strobe(strobe)
    );

endmodule

// File: rtl/tsa_checker.sv
module tsa_checker
    import tsa_pkg::*;
#(
    parameter int NCH = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr,
    input logic              cfg_ctl,
    input logic              cfg_bit0,
    input logic              fsync,
    input logic              run_en,
    input logic              seq_active,
    input logic [RUN_W-1:0]  seq_rem,
    input logic [NCH-1:0]    ch_clken,
    input logic [NCH-1:0]    ch_rxd,
    input logic              line_txd,
    input logic [STB_N-1:0]  strobe
);

    AST_CLKEN_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_clken)); // R5

    AST_IDLE_TX_HIGH: assert property (@(posedge clk) disable iff (rst)
        (ch_clken == '0) |-> line_txd); // R5

    AST_RX_ONLY_SELECTED: assert property (@(posedge clk) disable iff (rst)
        ((ch_rxd & ~ch_clken) == '0)); // R6

    AST_STROBE_HELD: assert property (@(posedge clk) disable iff (rst)
        (seq_active && seq_rem != '0 && !fsync && run_en) |=> $stable(strobe)); // R7

    AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !seq_active |-> (ch_clken == '0 && strobe == '0)); // R8

    AST_CLEAR_QUIETS: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_ctl && !cfg_bit0) |=> (ch_clken == '0 && strobe == '0)); // R12

endmodule

bind tdm_slot_assigner tsa_checker #(.NCH(NCH)) u_chk (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_ctl(cfg_ctl),
    .cfg_bit0(cfg_wdata[0]), .fsync(fsync), .run_en(run_en),
    .seq_active(active), .seq_rem(rem), .ch_clken(ch_clken),
    .ch_rxd(ch_rxd), .line_txd(line_txd), .strobe(strobe)
);

// File: tb/test_tdm_slot_assigner.sv
`timescale 1ns/1ps
module test_tdm_slot_assigner;

    localparam int NCH = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic        cfg_ctl = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        fsync = 1'b0;
    logic        line_rxd = 1'b0;
    logic        line_txd;
    logic [NCH-1:0] ch_txd = '0;
    logic [NCH-1:0] ch_clken;
    logic [NCH-1:0] ch_rxd;
    logic [3:0]  strobe;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] lst [64];

    always #2.5 clk = ~clk;

    tdm_slot_assigner i_tdm_slot_assigner (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_ctl(cfg_ctl),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .fsync(fsync),
        .line_rxd(line_rxd), .line_txd(line_txd), .ch_txd(ch_txd),
        .ch_clken(ch_clken), .ch_rxd(ch_rxd), .strobe(strobe)
    );

    function automatic logic [15:0] mk(int ch, int stb, bit bm, int cnt, bit last);
        return {3'(ch), 4'(stb), bm, 4'(cnt), 3'b000, last};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cfg_write(bit ctl, int addr, logic [15:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_ctl = ctl; cfg_addr = 6'(addr); cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic load_list(int n);
        cfg_write(1'b1, 0, 16'h0000);
        for (int i = 0; i < n; i++) cfg_write(1'b0, i, lst[i]);
        cfg_write(1'b1, 0, 16'h0001);
    endtask

    task automatic check_idle(string req);
        chk({req, " clken idle"}, 32'(ch_clken), 0);
        chk({req, " strobe idle"}, 32'(strobe), 0);
        chk({req, " txd idle high"}, 32'(line_txd), 1);
    endtask

    // Check one cycle against entry e, with fresh random data on the lanes.
    task automatic check_entry(logic [15:0] e, bit first);
        int c;
        bit vld;
        ch_txd   = NCH'($urandom);
        line_rxd = 1'($urandom);
        #1;
        c   = int'(e[15:13]);
        vld = (c >= 1 && c <= NCH);
        if (e[8])
            chk(first ? "R2 R4 clken" : "R4 clken", 32'(ch_clken), vld ? 32'(1 << (c - 1)) : 0);
        else
            chk(first ? "R2 R3 clken" : "R3 clken", 32'(ch_clken), vld ? 32'(1 << (c - 1)) : 0);
        if (vld) begin
            chk("R6 txd", 32'(line_txd), 32'(ch_txd[c-1]));
            chk("R6 rxd", 32'(ch_rxd), 32'(line_rxd) << (c - 1));
        end else begin
            chk("R5 idle txd", 32'(line_txd), 1);
            chk("R5 idle rxd", 32'(ch_rxd), 0);
        end
        chk("R7 strobe", 32'(strobe), 32'(e[12:9]));
    endtask

    // Pulse frame sync and follow the whole frame, then an idle tail.
    task automatic run_frame();
        int idx = 0;
        @(negedge clk);
        fsync = 1'b1;
        forever begin
            logic [15:0] e = lst[idx];
            int len = (int'(e[7:4]) + 1) * (e[8] ? 8 : 1);
            for (int b = 0; b < len; b++) begin
                @(negedge clk);
                fsync = 1'b0;
                check_entry(e, idx == 0 && b == 0);
            end
            if (e[0] || idx == 63) break;
            idx++;
        end
        for (int t = 0; t < 3; t++) begin
            @(negedge clk);
            #1;
            check_idle("R8");
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        check_idle("R1");

        // Directed mixed list: bit mode, byte mode, idle codes, strobes.
        lst[0] = mk(1, 4'b0001, 0, 0, 0);
        lst[1] = mk(3, 4'b1010, 1, 1, 0);
        lst[2] = mk(0, 4'b0100, 0, 3, 0);
        lst[3] = mk(6, 4'b1111, 0, 15, 0);
        lst[4] = mk(7, 4'b0000, 0, 2, 0);
        lst[5] = mk(2, 4'b0110, 1, 0, 1);
        lst[6] = mk(4, 4'b1000, 0, 5, 0);
        load_list(7);
        run_frame();
        run_frame();

        // R11: entry writes while enabled are dropped.
        cfg_write(1'b0, 0, mk(5, 4'b1111, 1, 15, 1));
        run_frame();

        // R9: sync in the middle of a run restarts the list.
        @(negedge clk); fsync = 1'b1;
        @(negedge clk); fsync = 1'b0;
        repeat (6) @(negedge clk);
        run_frame();

        // R12: clearing the enable mid-run idles the outputs next cycle.
        @(negedge clk); fsync = 1'b1;
        repeat (4) @(negedge clk);
        fsync = 1'b0;
        cfg_wr = 1'b1; cfg_ctl = 1'b1; cfg_wdata = 16'h0000;
        @(negedge clk);
        cfg_wr = 1'b0;
        #1;
        check_idle("R12");

        // R10: sync while disabled does nothing.
        fsync = 1'b1;
        @(negedge clk); fsync = 1'b0;
        for (int t = 0; t < 4; t++) begin
            @(negedge clk); #1;
            check_idle("R10");
        end

        // R8: a list with no last flag ends after entry 63.
        for (int i = 0; i < 64; i++) lst[i] = mk((i % 6) + 1, i % 16, 0, 0, 0);
        load_list(64);
        run_frame();

        // Random lists.
        for (int f = 0; f < 8; f++) begin
            int n = 1 + int'($urandom % 6);
            for (int i = 0; i < n; i++)
                lst[i] = mk(int'($urandom % 8), int'($urandom % 16), 1'($urandom),
                            int'($urandom % 16), i == n - 1);
            load_list(n);
            run_frame();
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule